// File: doc/BRIEF.md
# IR Run-Length Sampler

This block watches an already demodulated infrared receiver line and turns every stretch of constant level into a one-byte record. A mark (input high) and a space (input low) are timed in sample ticks. A prescaler makes one sample tick from a programmable number of one-microsecond strobes. The byte holds the polarity in its top bit and the length in the lower seven bits. A stretch too long for seven bits becomes a single saturated code.

The bytes go into an eight-entry store that is split into two halves of four. Each time a half is complete, a status bit names that half and an interrupt is raised. The host reads the finished half through a small read port while the hardware fills the other half. A separate enable lets a saturated stretch raise the interrupt as well. Such a stretch is the shortest gap that software can treat as the end of a transmission.

Top module: `ir_run_sampler`

## Requirements
- R1: Every stored byte carries the level of the stretch it describes in bit 7: 1 when `ir_in` was low (space), 0 when it was high (mark).
- R2: A sample tick occurs on every P-th `us_tick` strobe counted from the last level change, where P is `cfg_period[6:0]` (0 behaves as 1). Bits 6:0 of the byte are 1 plus the number of sample ticks seen before the change is detected. When `us_tick` is held high, a stretch of L clocks gives 1 + (L-1)/P.
- R3: When the length reaches 127 (0x7F), one byte with length 0x7F is stored at that moment. No further byte is stored for that stretch, including at the level change that ends it.
- R4: Bytes fill addresses 0 to 7 in order and wrap around. Addresses 0-3 form half 0 and addresses 4-7 form half 1. After the fourth byte of a half, `half_sel` shows that half's number. `rd_data` always shows the byte at `rd_addr`.
- R5: When `irq_en` is high, completing a half sets `irq`. `irq` then stays high until `irq_clr` is pulsed. A new set in the same cycle as `irq_clr` wins. When `irq_en` is low, completing a half leaves `irq` low.
- R6: With `cfg_period[7]` and `irq_en` both high, storing a saturated byte also sets `irq`. With `cfg_period[7]` low, it does not.
- R7: While `rx_en` is low, nothing is stored, `half_sel` holds, and the length count and prescaler are held at their restart values. The input level is still tracked, so re-enabling the receiver does not invent a change.
- R8: After reset `irq` is 0, `half_sel` is 1 and every buffer byte reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Demodulated IR level, 1 = mark |
| us_tick | input | 1 | One-microsecond strobe feeding the prescaler |
| rx_en | input | 1 | Receiver enable |
| irq_en | input | 1 | Interrupt enable |
| cfg_period | input | 8 | Bits 6:0 sample period in microseconds, bit 7 saturation interrupt enable |
| rd_addr | input | 3 | Buffer read address |
| rd_data | output | 8 | Byte at `rd_addr` |
| half_sel | output | 1 | Half that was completed last and is ready to read |
| irq | output | 1 | Interrupt pending |
| irq_clr | input | 1 | Clears the pending interrupt |

## Verification
The embedded properties check these rules on every cycle:
- no stored length is ever zero;
- a saturated stretch stores exactly one 0x7F byte;
- the write pointer and half status move only on a write, and the status changes on each completed half;
- the interrupt is sticky, and saturation raises it when enabled;
- nothing is written while the receiver is off.

Only the bench scenarios can show that the byte values match the tick arithmetic for several periods, including period 0. The same applies to the byte order across the two halves and wrap-around, the dropping of toggles made while disabled, and the effect of each interrupt enable.

// File: rtl/ir_samp_pkg.sv
package ir_samp_pkg;
    // width of the duration field in one stored byte
    localparam int unsigned LEN_W = 7;
    // saturated duration code
    localparam logic [LEN_W-1:0] LEN_SAT = '1;

    typedef struct packed {
        logic             is_space;
        logic [LEN_W-1:0] len;
    } sample_t;
endpackage

// File: rtl/ir_sync_edge.sv
module ir_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ir_in,
    output logic level,
    output logic change
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              lvl;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.sh  = {s_q.sh[STAGES-2:0], ir_in};
        s_d.lvl = s_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level  = s_q.lvl;
    assign change = s_q.sh[STAGES-1] != s_q.lvl;
endmodule

// File: rtl/ir_run_counter.sv
module ir_run_counter
    import ir_samp_pkg::*;
#(
    parameter int unsigned PER_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             us_tick,
    input  logic [PER_W-1:0] period,
    input  logic             level,
    input  logic             change,
    output logic             wr,
    output sample_t          wr_smp,
    output logic             ovf_hit
);
    localparam logic [PER_W-1:0] PER_ONE = {{(PER_W-1){1'b0}}, 1'b1};
    localparam logic [LEN_W-1:0] CNT_ONE = {{(LEN_W-1){1'b0}}, 1'b1};
    localparam logic [LEN_W-1:0] CNT_PRE = LEN_SAT - CNT_ONE;

    typedef struct packed {
        logic [PER_W-1:0] pre;
        logic [LEN_W-1:0] cnt;
        logic             sat;
    } st_t;

    localparam st_t RESTART = '{pre: '0, cnt: CNT_ONE, sat: 1'b0};

    st_t              s_d, s_q;
    logic [PER_W-1:0] per_last;
    logic             tick;

    always_comb begin
        per_last = (period == '0) ? '0 : period - PER_ONE;
        tick     = us_tick && (s_q.pre == per_last);
        s_d      = s_q;
        wr       = 1'b0;
        ovf_hit  = 1'b0;
        wr_smp   = '{is_space: !level, len: s_q.cnt};
        if (!en) begin
            s_d = RESTART;
        end else if (change) begin
            s_d = RESTART;
            wr  = !s_q.sat;
        end else begin
            if (us_tick) s_d.pre = tick ? '0 : s_q.pre + PER_ONE;
            if (tick && !s_q.sat) begin
                s_d.cnt = s_q.cnt + CNT_ONE;
                if (s_q.cnt == CNT_PRE) begin
                    s_d.sat    = 1'b1;
                    wr         = 1'b1;
                    ovf_hit    = 1'b1;
                    wr_smp.len = LEN_SAT;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RESTART;
        else        s_q <= s_d;
    end

    // R2
    nonzero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> wr_smp.len != '0);

    // R3
    sat_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.sat) |-> $past(wr && wr_smp.len == LEN_SAT));

    // R3
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.sat |-> s_q.cnt == LEN_SAT);
endmodule

// File: rtl/ir_pingpong_buf.sv
module ir_pingpong_buf #(
    parameter int unsigned HALF = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr,
    input  logic [7:0]                    wr_byte,
    input  logic [$clog2(2*HALF)-1:0]     rd_addr,
    output logic [7:0]                    rd_data,
    output logic                          half_sel,
    output logic                          half_done
);
    localparam int unsigned DEPTH = 2 * HALF;
    localparam int unsigned AW    = $clog2(DEPTH);
    localparam int unsigned OW    = AW - 1;
    localparam logic [AW-1:0] PTR_ONE = {{(AW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [AW-1:0]         ptr;
        logic                  hsel;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        half_done = wr && (s_q.ptr[OW-1:0] == '1);
        if (wr) begin
            s_d.mem[s_q.ptr] = wr_byte;
            s_d.ptr          = s_q.ptr + PTR_ONE;
        end
        if (half_done) s_d.hsel = s_q.ptr[AW-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{mem: '0, ptr: '0, hsel: 1'b1};
        else        s_q <= s_d;
    end

    assign rd_data  = s_q.mem[rd_addr];
    assign half_sel = s_q.hsel;

    // R4
    half_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_done |=> s_q.hsel != $past(s_q.hsel));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(s_q.ptr) && $stable(s_q.hsel));
endmodule

// File: rtl/ir_run_sampler.sv
module ir_run_sampler
    import ir_samp_pkg::*;
#(
    parameter int unsigned PER_W  = 7,
    parameter int unsigned HALF   = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ir_in,
    input  logic                      us_tick,
    input  logic                      rx_en,
    input  logic                      irq_en,
    input  logic [PER_W:0]            cfg_period,
    input  logic [$clog2(2*HALF)-1:0] rd_addr,
    output logic [7:0]                rd_data,
    output logic                      half_sel,
    output logic                      irq,
    input  logic                      irq_clr
);
    logic    level, change;
    logic    wr, ovf_hit, half_done;
    sample_t wr_smp;
    logic    irq_set;
    logic    irq_d, irq_q;

    ir_sync_edge #(.STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ir_in  (ir_in),
        .level  (level),
        .change (change)
    );

    ir_run_counter #(.PER_W(PER_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (rx_en),
        .us_tick (us_tick),
        .period  (cfg_period[PER_W-1:0]),
        .level   (level),
        .change  (change),
        .wr      (wr),
        .wr_smp  (wr_smp),
        .ovf_hit (ovf_hit)
    );

    ir_pingpong_buf #(.HALF(HALF)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr),
        .wr_byte   (wr_smp),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .half_sel  (half_sel),
        .half_done (half_done)
    );

    always_comb begin
        irq_set = irq_en && (half_done || (ovf_hit && cfg_period[PER_W]));
        irq_d   = irq_set || (irq_q && !irq_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;

    // R5
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q && !irq_clr |=> irq_q);

    // R5
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_q && !half_done && !ovf_hit |=> !irq_q);

    // R6
    sat_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_hit && cfg_period[PER_W] && irq_en |=> irq_q);

    // R7
    rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |-> !wr);
endmodule

// File: tb/sim_ir_run_sampler.sv
`timescale 1ns/1ps
module sim_ir_run_sampler;
    logic       clk = 1'b0;
    logic       rst_n, ir_in, us_tick, rx_en, irq_en, irq_clr;
    logic [7:0] cfg_period;
    logic [2:0] rd_addr;
    logic [7:0] rd_data;
    logic       half_sel, irq;

    always #4 clk = ~clk;

    ir_run_sampler u0 (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .us_tick(us_tick),
        .rx_en(rx_en), .irq_en(irq_en), .cfg_period(cfg_period),
        .rd_addr(rd_addr), .rd_data(rd_data), .half_sel(half_sel),
        .irq(irq), .irq_clr(irq_clr)
    );

    int   checks = 0, errors = 0, npush = 0, per_now = 0;
    logic [7:0] exp_q[$];
    bit   cur_lvl = 1'b0, cur_done = 1'b1, exp_irq_en = 1'b0, ready = 1'b0;
    int   cur_len = 3;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int len_of(input int len, input int per);
        int p = (per == 0) ? 1 : per;
        return 1 + (len - 1) / p;
    endfunction

    function automatic logic [7:0] code_of(input bit lvl, input int len, input int per);
        int n = len_of(len, per);
        return {~lvl, (n >= 127) ? 7'h7F : 7'(n)};
    endfunction

    task automatic push(input logic [7:0] v);
        exp_q.push_back(v);
        npush++;
    endtask

    // called at a falling edge; drives a new level and holds it len clocks
    task automatic run(input bit lvl, input int len, input int probe = 0,
                       input bit probe_irq = 1'b0, input string tag = "");
        if (!cur_done) push(code_of(cur_lvl, cur_len, per_now));
        ir_in    = lvl;
        cur_lvl  = lvl;
        cur_len  = len;
        cur_done = 1'b0;
        if (len_of(len, per_now) >= 127) begin
            push(code_of(lvl, len, per_now));
            cur_done = 1'b1;
        end
        if (probe > 0) begin
            repeat (probe) @(negedge clk);
            check(irq == 1'b0, "R6 no irq before saturation", irq, 0);
            repeat (len - probe) @(negedge clk);
            check(irq == probe_irq, tag, irq, probe_irq);
        end else begin
            repeat (len) @(negedge clk);
        end
    endtask

    task automatic rx_off_toggles;
        logic hs0, irq0;
        run(~cur_lvl, 5);
        rx_en    = 1'b0;
        cur_done = 1'b1;
        hs0      = half_sel;
        irq0     = irq;
        for (int i = 0; i < 7; i++) begin
            ir_in = ~ir_in;
            repeat (4) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check(half_sel == hs0, "R7 half_sel held while disabled", half_sel, hs0);
        check(irq == irq0, "R7 irq held while disabled", irq, irq0);
    endtask

    task automatic rx_on;
        rx_en    = 1'b1;
        cur_lvl  = ir_in;
        cur_len  = 3;
        cur_done = 1'b0;
    endtask

    // reads each completed half and compares with the expected stream
    initial begin
        logic       last_hs;
        logic [7:0] got, e;
        rd_addr = '0;
        irq_clr = 1'b0;
        @(posedge rst_n);
        @(negedge clk);
        // R8
        check(irq == 1'b0, "R8 irq after reset", irq, 0);
        check(half_sel == 1'b1, "R8 half_sel after reset", half_sel, 1);
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #0.2;
            check(rd_data == 8'h00, "R8 buffer cleared", rd_data, 0);
        end
        last_hs = half_sel;
        ready   = 1'b1;
        forever begin
            @(negedge clk);
            if (half_sel !== last_hs) begin
                last_hs = half_sel;
                for (int i = 0; i < 4; i++) begin
                    rd_addr = {half_sel, 2'(i)};
                    #0.2;
                    got = rd_data;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R4 unexpected extra byte", got, 0);
                    end else begin
                        e = exp_q.pop_front();
                        check(got == e, "R1/R2/R3 stored byte", got, e);
                    end
                end
                check(irq == exp_irq_en, "R5 irq on half completion", irq, exp_irq_en);
                if (irq) begin
                    irq_clr = 1'b1;
                    @(negedge clk);
                    irq_clr = 1'b0;
                    check(irq == 1'b0, "R5 irq cleared", irq, 0);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lens[12] = '{4, 126, 127, 128, 3, 300, 7, 20, 60, 126, 3, 9};
        int will;
        void'($urandom(32'd1234));
        rst_n = 1'b0; ir_in = 1'b0; us_tick = 1'b1; rx_en = 1'b0;
        irq_en = 1'b0; cfg_period = 8'h01;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wait (ready);
        @(negedge clk);

        // phase A: period 1, directed boundary lengths then random
        per_now = 1; irq_en = 1'b1; exp_irq_en = 1'b1;
        rx_on();
        foreach (lens[i]) run(~cur_lvl, lens[i]);
        for (int i = 0; i < 30; i++) run(~cur_lvl, 3 + int'($urandom % 200));

        // R6: saturation with the saturation interrupt disabled, then enabled
        for (int t = 0; t < 2; t++) begin
            cfg_period[7] = (t == 1);
            while (((npush + (cur_done ? 0 : 1) + 1) % 4) == 0 ||
                   ((npush + (cur_done ? 0 : 1)) % 4) == 0)
                run(~cur_lvl, 6);
            run(~cur_lvl, 200, 120, t == 1,
                (t == 1) ? "R6 saturation sets irq" : "R6 saturation irq masked");
            for (int i = 0; i < 8; i++) run(~cur_lvl, 6);
        end
        cfg_period[7] = 1'b0;

        // phase B: period 3, interrupts off, after a disabled stretch
        rx_off_toggles();
        cfg_period = 8'h03; per_now = 3; irq_en = 1'b0; exp_irq_en = 1'b0;
        rx_on();
        for (int i = 0; i < 40; i++) run(~cur_lvl, 3 + int'($urandom % 500));

        // phase C: period 0 behaves as 1
        rx_off_toggles();
        cfg_period = 8'h00; per_now = 0; irq_en = 1'b1; exp_irq_en = 1'b1;
        rx_on();
        for (int i = 0; i < 30; i++) run(~cur_lvl, 3 + int'($urandom % 200));

        // flush so that every expected byte completes a half
        forever begin
            will = npush + (cur_done ? 0 : 1);
            run(~cur_lvl, 6);
            if (will % 4 == 0) break;
        end
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R4 all bytes read back", exp_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule